// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets synchronous logic use an external 512K x 8 asynchronous static RAM. The memory has two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and a shared 8-bit data bus. Tri-state pads are modelled as three separate signals: a bus value, a bus drive enable and a bus input. The user side issues one-cycle read or write pulses that carry an address and data. The block raises `busy` while a memory cycle is in flight. For a read it returns the captured byte together with a one-cycle `rdValid`.

The length of every memory cycle is set by clock-count parameters that come from the memory's timing minimums. A read holds the chip selected, with output enable active, for `RD_CYC` cycles. A write has three phases: one setup cycle, then a write strobe of `WP_CYC` cycles, then one closing cycle. The address only moves while the chip is deselected.

Holding `sleepReq` parks the memory in its low-power retention state. In that state the active-high select is low. When `sleepReq` drops, the block waits one full read-cycle time before it accepts new work. The block makes the same wait after reset.

Top module: `sram_async_ctl`

## Requirements
- R1: While `rstN` is low, the pads have these values: `memCe1N`=1, `memCe2`=0, `memWeN`=1, `memOeN`=1 and `memDqOe`=0. `busy` is 1.
- R2: After reset is released, and again after `sleepReq` is released, `busy` stays 1 for exactly `RD_CYC` cycles (default 7) before a request can be accepted. During that wait `memCe2` is 1.
- R3: While idle, the memory is deselected: `memCe1N`=1, `memWeN`=1 and `memOeN`=1, and the bus driver is off.
- R4: A read keeps `memCe1N`=0, `memCe2`=1, `memOeN`=0 and `memWeN`=1 for `RD_CYC` cycles. The bus is sampled at the end of the last of those cycles. `rdData` is presented with `rdValid` high for exactly one cycle, `RD_CYC`+1 cycles after the request cycle.
- R5: A write drives `memWeN` low for exactly `WP_CYC` consecutive cycles (default 5), always inside `memCe1N`=0 and `memCe2`=1. The byte is stored in the memory.
- R6: Whenever `memAddr` changes, at least one of the three controls is inactive, both in the cycle before the change and in the cycle of the change. The three controls are `memCe1N` high, `memCe2` low and `memWeN` high.
- R7: The block drives the bus only while `memWeN`=0 or `memOeN`=1. It never drives the bus during a read.
- R8: The write data and address stay constant on the pads for at least `DS_CYC` cycles (default 3) before `memWeN` rises.
- R9: Any request that arrives while `busy`=1 is dropped. It causes no memory cycle and no `rdValid`.
- R10: If `sleepReq` is high in idle, `memCe2` goes low and `memCe1N` stays high, with `busy`=1, until `sleepReq` falls. Stored data survives this.
- R11: When several requests arrive in the same idle cycle, read wins over write, and write wins over retention. A request that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | One-cycle read request |
| wrReq | input | 1 | One-cycle write request |
| reqAddr | input | ADDR_W | Request address |
| reqWrData | input | DATA_W | Write data |
| sleepReq | input | 1 | Level request for retention state |
| busy | output | 1 | High whenever a request cannot be accepted |
| rdData | output | DATA_W | Captured read byte |
| rdValid | output | 1 | One-cycle pulse marking rdData |
| memAddr | output | ADDR_W | Memory address pins |
| memCe1N | output | 1 | Active-low chip select |
| memCe2 | output | 1 | Active-high chip select, low in retention |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memDqOut | output | DATA_W | Value driven onto the data bus |
| memDqOe | output | 1 | Data bus driver enable |
| memDqIn | input | DATA_W | Value read from the data bus |

## Verification
The hardest case to reach is a read capture that lands one cycle early. A simple memory model would hide it. The bench model therefore returns the inverted byte until the read controls have been held for `RD_CYC`-1 full cycles. It returns the stored byte only after that, so any shortened read shows up as a data mismatch. Requests dropped while busy are forced by pulsing `rdReq` and `wrReq` in the middle of a write strobe and during retention. The bench then reads back the target addresses and counts every `rdValid` against the scoreboard queue.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_WAIT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_END,
    ST_RETAIN,
    ST_RECOVER
  } ctlState_e;

  // Strobes from control to datapath; pin fields describe the next cycle.
  typedef struct packed {
    logic selN;
    logic ce2;
    logic weN;
    logic oeN;
    logic dqDrive;
    logic ldReq;
    logic capRd;
  } pinStrobe_t;

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC = 7,
  parameter int WP_CYC = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       wrReq,
  input  logic       sleepReq,
  output logic       busy,
  output pinStrobe_t strobe
);

  localparam int MAX_CYC = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);

  ctlState_e        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RETAIN;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  // Next state, phase counter and one-shot strobes
  always_comb begin
    stateNext     = state;
    cntNext       = cnt + 1'b1;
    strobe.ldReq  = 1'b0;
    strobe.capRd  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cntNext = '0;
        if (rdReq) begin
          stateNext    = ST_READ_WAIT;
          strobe.ldReq = 1'b1;
        end else if (wrReq) begin
          stateNext    = ST_WR_SETUP;
          strobe.ldReq = 1'b1;
        end else if (sleepReq) begin
          stateNext = ST_RETAIN;
        end
      end
      ST_READ_WAIT: begin
        if (cnt == RD_LAST) begin
          stateNext    = ST_IDLE;
          cntNext      = '0;
          strobe.capRd = 1'b1;
        end
      end
      ST_WR_SETUP: begin
        stateNext = ST_WR_PULSE;
        cntNext   = '0;
      end
      ST_WR_PULSE: begin
        if (cnt == WP_LAST) begin
          stateNext = ST_WR_END;
          cntNext   = '0;
        end
      end
      ST_WR_END: begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
      ST_RETAIN: begin
        cntNext = '0;
        if (!sleepReq) stateNext = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (cnt == RD_LAST) begin
          stateNext = ST_IDLE;
          cntNext   = '0;
        end
      end
      default: begin
        stateNext = ST_RETAIN;
        cntNext   = '0;
      end
    endcase
  end

  // Pin levels decoded from the next state, registered in the datapath
  always_comb begin
    strobe.selN    = 1'b1;
    strobe.ce2     = 1'b1;
    strobe.weN     = 1'b1;
    strobe.oeN     = 1'b1;
    strobe.dqDrive = 1'b0;
    unique case (stateNext)
      ST_READ_WAIT: begin
        strobe.selN = 1'b0;
        strobe.oeN  = 1'b0;
      end
      ST_WR_SETUP, ST_WR_END: begin
        strobe.selN    = 1'b0;
        strobe.dqDrive = 1'b1;
      end
      ST_WR_PULSE: begin
        strobe.selN    = 1'b0;
        strobe.weN     = 1'b0;
        strobe.dqDrive = 1'b1;
      end
      ST_RETAIN: strobe.ce2 = 1'b0;
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  // Control pads: registered so each pin changes only on a clock edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCe1N <= 1'b1;
      memCe2  <= 1'b0;
      memWeN  <= 1'b1;
      memOeN  <= 1'b1;
      memDqOe <= 1'b0;
    end else begin
      memCe1N <= strobe.selN;
      memCe2  <= strobe.ce2;
      memWeN  <= strobe.weN;
      memOeN  <= strobe.oeN;
      memDqOe <= strobe.dqDrive;
    end
  end

  // Address and write data held from acceptance until the next request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
    end else if (strobe.ldReq) begin
      memAddr  <= reqAddr;
      memDqOut <= reqWrData;
    end
  end

  // Read return
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.capRd;
      if (strobe.capRd) rdData <= memDqIn;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int RD_CYC = 7,
  parameter int WP_CYC = 5,
  parameter int DS_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              sleepReq,
  output logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  pinStrobe_t strobe;

  sram_ctl_fsm #(
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .rdReq   (rdReq),
    .wrReq   (wrReq),
    .sleepReq(sleepReq),
    .busy    (busy),
    .strobe  (strobe)
  );

  sram_ctl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWrData(reqWrData),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .memCe1N  (memCe1N),
    .memCe2   (memCe2),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int RD_CYC = 7,
  parameter int DS_CYC = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  localparam int LIM    = (RD_CYC > DS_CYC) ? RD_CYC : DS_CYC;
  localparam int CNT_W  = $clog2(LIM + 2);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] ceHiCnt;  // cycles since select-high returned
  logic [CNT_W-1:0] dsCnt;    // cycles data and address held while driving
  logic             seenClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceHiCnt <= '0;
      dsCnt   <= '0;
      seenClk <= 1'b0;
    end else begin
      seenClk <= 1'b1;
      if (!memCe2) ceHiCnt <= '0;
      else if (ceHiCnt != SAT) ceHiCnt <= ceHiCnt + 1'b1;
      if (!memDqOe) dsCnt <= '0;
      else if (dsCnt != SAT) dsCnt <= dsCnt + 1'b1;
    end
  end

  assert_recover_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ceHiCnt >= CNT_W'(RD_CYC));

  assert_idle_parked_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memCe1N && memWeN && memOeN && !memDqOe));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  assert_strobe_in_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCe1N && memCe2));

  assert_addr_quiet_R6: assert property (@(posedge clk) disable iff (!rstN || !seenClk)
    !$stable(memAddr) |-> ((memCe1N || !memCe2 || memWeN) &&
                           ($past(memCe1N) || !$past(memCe2) || $past(memWeN))));

  assert_bus_turn_R7: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWeN || memOeN));

  assert_data_setup_R8: assert property (@(posedge clk) disable iff (!rstN || !seenClk)
    $rose(memWeN) |-> (dsCnt >= CNT_W'(DS_CYC) && $stable(memDqOut) && $stable(memAddr)));

  assert_retain_parked_R10: assert property (@(posedge clk) disable iff (!rstN)
    !memCe2 |-> (memCe1N && busy));

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .RD_CYC(RD_CYC),
  .DS_CYC(DS_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .rdValid (rdValid),
  .memAddr (memAddr),
  .memCe1N (memCe1N),
  .memCe2  (memCe2),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memDqOut(memDqOut),
  .memDqOe (memDqOe)
);

// File: tb/sram_async_ctl_bench.sv
module sram_async_ctl_bench;

  localparam int AW  = 19;
  localparam int DW  = 8;
  localparam int RDC = 7;
  localparam int WPC = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdReq = 1'b0, wrReq = 1'b0, sleepReq = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWrData = '0;
  logic          busy, rdValid, memCe1N, memCe2, memWeN, memOeN, memDqOe;
  logic [DW-1:0] rdData, memDqOut, memDqIn;
  logic [AW-1:0] memAddr;

  int total = 0;
  int bad = 0;
  int validSeen = 0;
  int readsIssued = 0;

  always #5 clk = ~clk;

  sram_async_ctl u_sram_async_ctl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .sleepReq(sleepReq), .busy(busy), .rdData(rdData),
    .rdValid(rdValid), .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  // ---------------- memory model ----------------
  logic [DW-1:0] sram [int];
  logic [DW-1:0] refMem [int];
  int            age = 0;
  logic          pendValid = 1'b0;
  logic [AW-1:0] pendAddr;
  logic [DW-1:0] pendData;

  function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : '0;
  endfunction

  wire readOn = !memCe1N && memCe2 && !memOeN && memWeN;
  wire wrOvl  = !memCe1N && memCe2 && !memWeN;

  always @(posedge clk) begin
    age <= readOn ? age + 1 : 0;
    if (wrOvl) begin
      pendValid <= 1'b1;
      pendAddr  <= memAddr;
      pendData  <= memDqOut;
    end else if (pendValid) begin
      sram[int'(pendAddr)] = pendData;
      pendValid <= 1'b0;
    end
  end

  // Byte is wrong until the read has been held for a full access time
  always_comb begin
    if (!readOn) memDqIn = '0;
    else if (age >= RDC - 1) memDqIn = peek(memAddr);
    else memDqIn = ~peek(memAddr);
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- scoreboard monitor ----------------
  logic [DW-1:0] expQ[$];
  logic prevValid = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid && prevValid) check(0, "R4", "rdValid wider than one cycle", 2, 1);
      if (rdValid) begin
        validSeen++;
        if (expQ.size() == 0) begin
          check(0, "R9", "rdValid with no read outstanding", 1, 0);
        end else begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          check(rdData == e, "R4", "read data", rdData, e);
        end
      end
      prevValid <= rdValid;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic doRead(input logic [AW-1:0] a);
    int k;
    waitIdle();
    rdReq = 1'b1; reqAddr = a;
    expQ.push_back(refMem.exists(int'(a)) ? refMem[int'(a)] : '0);
    readsIssued++;
    @(negedge clk);
    rdReq = 1'b0;
    check(!memCe1N && memCe2 && !memOeN && memWeN, "R4", "read pin levels",
          {memCe1N, memCe2, memOeN, memWeN}, 4'b0101);
    check(!memDqOe, "R7", "driver off in read", memDqOe, 0);
    k = 1;
    while (!rdValid && k < 50) begin
      @(negedge clk);
      k++;
    end
    check(k == RDC + 1, "R4", "read latency", k, RDC + 1);
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lowCnt;
    bit addrOk, dataOk;
    waitIdle();
    wrReq = 1'b1; reqAddr = a; reqWrData = d;
    refMem[int'(a)] = d;
    @(negedge clk);
    wrReq = 1'b0;
    reqAddr = ~a; reqWrData = ~d;
    lowCnt = 0; addrOk = 1; dataOk = 1;
    while (busy) begin
      if (!memWeN) begin
        lowCnt++;
        if (memAddr != a) addrOk = 0;
        if (memDqOut != d || !memDqOe) dataOk = 0;
      end
      @(negedge clk);
    end
    check(lowCnt == WPC, "R5", "write strobe width", lowCnt, WPC);
    check(addrOk, "R6", "address steady under strobe", addrOk, 1);
    check(dataOk, "R8", "data driven and steady under strobe", dataOk, 1);
  endtask

  task automatic countBusy(input string req, input string what);
    int n;
    bit ce2Ok;
    n = 0; ce2Ok = 1;
    while (busy && n < 100) begin
      n++;
      if (!memCe2) ce2Ok = 0;
      @(negedge clk);
    end
    check(n == RDC, req, what, n, RDC);
    check(ce2Ok, req, "select-high during recovery", ce2Ok, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #1_000_000;
    check(0, "R2", "watchdog expired", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1 reset levels
    check(memCe1N && !memCe2 && memWeN && memOeN && !memDqOe && busy, "R1",
          "reset pin levels", {memCe1N, memCe2, memWeN, memOeN, memDqOe, busy},
          6'b101101);
    rstN = 1'b1;
    @(negedge clk);
    countBusy("R2", "recovery after reset");

    // R3 idle parking
    repeat (2) @(negedge clk);
    check(memCe1N && memWeN && memOeN && !memDqOe, "R3", "idle pin levels",
          {memCe1N, memWeN, memOeN, memDqOe}, 4'b1110);

    doWrite(19'h00000, 8'h3C);
    doWrite(19'h7FFFF, 8'hC3);
    doWrite(19'h12345, 8'hA5);
    doRead(19'h00000);
    doRead(19'h7FFFF);
    doRead(19'h12345);
    doRead(19'h00055);
    doWrite(19'h12345, 8'h5A);
    doRead(19'h12345);

    // R9 requests during a write are dropped
    waitIdle();
    wrReq = 1'b1; reqAddr = 19'h00100; reqWrData = 8'h77;
    refMem[int'(19'h00100)] = 8'h77;
    @(negedge clk);
    wrReq = 1'b0;
    repeat (2) @(negedge clk);
    rdReq = 1'b1; wrReq = 1'b1; reqAddr = 19'h00200; reqWrData = 8'hEE;
    @(negedge clk);
    rdReq = 1'b0; wrReq = 1'b0;
    waitIdle();
    repeat (RDC + 3) @(negedge clk);
    check(validSeen == readsIssued, "R9", "no rdValid from dropped read",
          validSeen, readsIssued);
    doRead(19'h00200);
    doRead(19'h00100);

    // R11 read beats write in the same cycle
    waitIdle();
    rdReq = 1'b1; wrReq = 1'b1; reqAddr = 19'h0003C; reqWrData = 8'h99;
    expQ.push_back(8'h00);
    readsIssued++;
    @(negedge clk);
    rdReq = 1'b0; wrReq = 1'b0;
    check(!memOeN && memWeN, "R11", "read chosen over write", {memOeN, memWeN}, 2'b01);
    doRead(19'h0003C);

    // R10 retention, with a read attempted inside it
    waitIdle();
    sleepReq = 1'b1;
    @(negedge clk);
    check(!memCe2 && memCe1N && busy, "R10", "retention pin levels",
          {memCe2, memCe1N, busy}, 3'b011);
    repeat (5) @(negedge clk);
    rdReq = 1'b1; reqAddr = 19'h7FFFF;
    @(negedge clk);
    rdReq = 1'b0;
    repeat (10) @(negedge clk);
    check(!memCe2 && busy, "R10", "retention held while requested",
          {memCe2, busy}, 2'b01);
    sleepReq = 1'b0;
    @(negedge clk);
    countBusy("R2", "recovery after retention");
    check(validSeen == readsIssued, "R9", "read during retention dropped",
          validSeen, readsIssued);
    doRead(19'h7FFFF);
    doRead(19'h00000);

    repeat (RDC + 4) @(negedge clk);
    check(expQ.size() == 0, "R4", "all reads returned", expQ.size(), 0);
    check(validSeen == readsIssued, "R4", "rdValid count", validSeen, readsIssued);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule